// File: doc/BRIEF.md
# Stack-Distance Cache Profiler with Write-Back Projection

This block is a per-core shadow monitor for a shared last-level cache. It watches the stream of accesses that one core sends to the cache and predicts, for every possible way allocation at once, how many misses that core would suffer and how many dirty lines it would write back to memory. The real cache, its data array and the partitioning policy that uses the estimates live elsewhere. The monitor keeps only a small shadow directory. It samples one set in every 32, stores 11-bit hashed tags instead of full tags, and limits each shadow set to the deepest allocation one core may receive (9 of 16 ways).

Each monitored set is a true-LRU stack. When an access hits, its depth from the MRU end is recorded in a histogram of hit counters, and the line moves to MRU. When an access misses the whole stack, a miss counter advances, the new tag enters at MRU and the LRU entry falls out. Every entry also carries a dirty flag and a register that holds the deepest position at which the dirty line was re-referenced. When a dirty line falls out of the stack, the dirty counter selected by that recorded depth advances once. A combinational query returns the projected miss count and write-back count for a chosen number of ways. A synchronous clear starts a new measurement epoch.

Top module: `llcprof_top`

## Requirements
- R1: An access is monitored only when the low 5 bits of its set index (address bits 10:6, with 64-byte lines and set index in bits 15:6) are all zero. Any other access changes no counter and no stack contents. The monitored shadow set is selected by address bits 15:11.
- R2: The stored tag is an 11-bit fold of address bits 31:16. Upper bit i is XORed into tag bit i mod 11. Two addresses of one set whose folds are equal are treated as the same line.
- R3: On a hit at position p of the stack (0 = MRU, 8 = LRU), hit counter p advances by one and the line moves to MRU. The entries that were above it each move down by one position.
- R4: A shadow set holds at most 9 lines. Bringing in a tenth distinct tag pushes out the LRU line, so a later access to that line misses.
- R5: An access that matches no valid entry advances the stack-miss counter by one and inserts its tag at MRU.
- R6: A store sets the line's dirty flag. A line that becomes dirty starts with a recorded depth of 0. Every later hit to a dirty line, whether load or store, raises the recorded depth to its hit position if that position is larger.
- R7: When a dirty line is pushed out of the stack, dirty counter d advances exactly once, where d is its recorded depth. Pushing out a clean line changes no dirty counter. Repeated stores to a resident line do not add counts.
- R8: Asserting clear zeroes every hit, miss and dirty counter on the next edge. An access presented in the same cycle is counted on top of the zeroed values. The stacks are not touched by clear.
- R9: For a query of W ways (0 to 9), the miss estimate equals the stack-miss counter plus the sum of hit counters at positions W and deeper. Sums wrap modulo 2^32.
- R10: For a query of W ways, the write-back estimate equals the sum of dirty counters at depths W and deeper.
- R11: After reset, every counter and both estimates are zero and every shadow set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Epoch clear of all counters |
| acc_valid_i | input | 1 | Access record valid |
| acc_addr_i | input | 32 | Byte address of the access |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| query_ways_i | input | 4 | Way allocation W for the estimates |
| hit_cnt_o | output | 288 | Hit counters, position d at bits d*32 +: 32 |
| stack_miss_cnt_o | output | 32 | Accesses that missed the whole stack |
| dirty_cnt_o | output | 288 | Dirty eviction counters, depth d at bits d*32 +: 32 |
| est_miss_o | output | 32 | Projected misses for W ways |
| est_wb_o | output | 32 | Projected write-backs for W ways |

## Verification
The assertions assume that query_ways_i never exceeds 9. They also assume that the shadow directory holds no two valid entries with the same hashed tag in one set, which the insertion rule itself maintains. Counter checks that compare against the previous value assume the counters do not wrap during a run. The stimulus keeps the query in range, draws tags from a small pool so that hits, evictions and hash aliases occur often, and stays far below 2^32 events.

// File: rtl/llcprof_pkg.sv
`timescale 1ns/1ps
package llcprof_pkg;
    localparam int TAG_W = 11;
    localparam int DD_W  = 6;

    typedef struct packed {
        logic             vld;
        logic             dirty;
        logic [DD_W-1:0]  maxd;
        logic [TAG_W-1:0] tag;
    } ent_t;
endpackage

// File: rtl/llcprof_hash.sv
`timescale 1ns/1ps
module llcprof_hash #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 11
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [OUT_W-1:0] hash_o
);
    // fold: input bit i lands on output bit i mod OUT_W
    always_comb begin
        hash_o = '0;
        for (int i = 0; i < IN_W; i++) begin
            hash_o[i % OUT_W] = hash_o[i % OUT_W] ^ bits_i[i];
        end
    end
endmodule

// File: rtl/llcprof_stack.sv
`timescale 1ns/1ps
module llcprof_stack
    import llcprof_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int WAYS  = 9,
    parameter int IDX_W = 5,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             store_i,
    output logic             hit_o,
    output logic [POS_W-1:0] hit_pos_o,
    output logic             evict_dirty_o,
    output logic [DD_W-1:0]  evict_maxd_o
);
    ent_t mem_q [SETS][WAYS];
    ent_t row   [WAYS];
    ent_t row_d [WAYS];
    ent_t moved;
    logic [WAYS-1:0] match;

    always_comb begin
        row = mem_q[idx_i];
        for (int k = 0; k < WAYS; k++) begin
            match[k] = row[k].vld && (row[k].tag == tag_i);
        end
    end

    always_comb begin
        hit_pos_o = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (match[k]) hit_pos_o = POS_W'(k);
        end
        hit_o = |match;
    end

    // next row: move hit entry to MRU, or insert new tag and drop LRU
    always_comb begin
        moved         = row[hit_pos_o];
        evict_dirty_o = 1'b0;
        evict_maxd_o  = row[WAYS-1].maxd;
        if (moved.dirty) begin
            if (DD_W'(hit_pos_o) > moved.maxd) moved.maxd = DD_W'(hit_pos_o);
        end else if (store_i) begin
            moved.maxd = '0;
        end
        moved.dirty = moved.dirty | store_i;
        if (hit_o) begin
            for (int k = 0; k < WAYS; k++) begin
                if (k == 0)                   row_d[k] = moved;
                else if (k <= int'(hit_pos_o)) row_d[k] = row[k-1];
                else                          row_d[k] = row[k];
            end
        end else begin
            evict_dirty_o = row[WAYS-1].vld && row[WAYS-1].dirty;
            row_d[0] = '{vld: 1'b1, dirty: store_i, maxd: '0, tag: tag_i};
            for (int k = 1; k < WAYS; k++) row_d[k] = row[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int k = 0; k < WAYS; k++) mem_q[s][k] <= '0;
            end
        end else if (acc_en_i) begin
            mem_q[idx_i] <= row_d;
        end
    end

    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en_i |-> $onehot0(match));
    p_mru_after_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en_i |=> (mem_q[$past(idx_i)][0].tag == $past(tag_i)) && mem_q[$past(idx_i)][0].vld);
    p_store_marks_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && store_i) |=> mem_q[$past(idx_i)][0].dirty);
    p_maxd_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_dirty_o |-> (int'(evict_maxd_o) < WAYS));
endmodule

// File: rtl/llcprof_cnt.sv
`timescale 1ns/1ps
module llcprof_cnt #(
    parameter int WAYS  = 9,
    parameter int POS_W = 4,
    parameter int DD_W  = 6,
    parameter int CNT_W = 32,
    parameter int QW_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  ev_i,
    input  logic                  ev_hit_i,
    input  logic [POS_W-1:0]      ev_pos_i,
    input  logic                  ev_evict_dirty_i,
    input  logic [DD_W-1:0]       ev_maxd_i,
    input  logic [QW_W-1:0]       query_i,
    output logic [WAYS*CNT_W-1:0] hit_o,
    output logic [CNT_W-1:0]      miss_o,
    output logic [WAYS*CNT_W-1:0] dirty_o,
    output logic [CNT_W-1:0]      est_miss_o,
    output logic [CNT_W-1:0]      est_wb_o
);
    typedef struct packed {
        logic [WAYS-1:0][CNT_W-1:0] hit;
        logic [CNT_W-1:0]           miss;
        logic [WAYS-1:0][CNT_W-1:0] dirt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) st_d = '0;
        if (ev_i) begin
            if (ev_hit_i) st_d.hit[ev_pos_i] = st_d.hit[ev_pos_i] + CNT_W'(1);
            else          st_d.miss          = st_d.miss + CNT_W'(1);
            if (ev_evict_dirty_i)
                st_d.dirt[int'(ev_maxd_i)] = st_d.dirt[int'(ev_maxd_i)] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        est_miss_o = st_q.miss;
        est_wb_o   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (w >= int'(query_i)) begin
                est_miss_o = est_miss_o + st_q.hit[w];
                est_wb_o   = est_wb_o + st_q.dirt[w];
            end
        end
    end

    assign hit_o   = st_q.hit;
    assign miss_o  = st_q.miss;
    assign dirty_o = st_q.dirt;

    p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !ev_i) |=> (miss_o == '0) && (hit_o == '0) && (dirty_o == '0));
    p_miss_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !ev_hit_i && !clear_i) |=> miss_o == $past(miss_o) + CNT_W'(1));
    p_hit_keeps_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && ev_hit_i && !clear_i) |=> miss_o == $past(miss_o));
    p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i && !clear_i) |=> $stable(hit_o) && $stable(dirty_o) && $stable(miss_o));
    p_query_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(query_i) <= WAYS);
endmodule

// File: rtl/llcprof_top.sv
`timescale 1ns/1ps
module llcprof_top #(
    parameter int ADDR_W      = 32,
    parameter int LINE_OFF    = 6,
    parameter int SET_BITS    = 10,
    parameter int SAMPLE_LOG2 = 5,
    parameter int LLC_WAYS    = 16,
    parameter int CNT_W       = 32,
    parameter int MAX_WAYS    = (LLC_WAYS * 9) / 16,
    parameter int QW_W        = $clog2(MAX_WAYS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      acc_valid_i,
    input  logic [ADDR_W-1:0]         acc_addr_i,
    input  logic                      acc_store_i,
    input  logic [QW_W-1:0]           query_ways_i,
    output logic [MAX_WAYS*CNT_W-1:0] hit_cnt_o,
    output logic [CNT_W-1:0]          stack_miss_cnt_o,
    output logic [MAX_WAYS*CNT_W-1:0] dirty_cnt_o,
    output logic [CNT_W-1:0]          est_miss_o,
    output logic [CNT_W-1:0]          est_wb_o
);
    import llcprof_pkg::*;

    localparam int IDX_W    = SET_BITS - SAMPLE_LOG2;
    localparam int MON_SETS = 1 << IDX_W;
    localparam int POS_W    = $clog2(MAX_WAYS);
    localparam int HI_LSB   = LINE_OFF + SET_BITS;
    localparam int HI_W     = ADDR_W - HI_LSB;

    logic             sampled, acc_en;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit, evict_dirty;
    logic [POS_W-1:0] hit_pos;
    logic [DD_W-1:0]  evict_maxd;
    logic             unused_offset;

    assign unused_offset = ^acc_addr_i[LINE_OFF-1:0];
    assign sampled = (acc_addr_i[LINE_OFF +: SAMPLE_LOG2] == '0);
    assign acc_en  = acc_valid_i && sampled;
    assign idx     = acc_addr_i[LINE_OFF + SAMPLE_LOG2 +: IDX_W];

    llcprof_hash #(.IN_W(HI_W), .OUT_W(TAG_W)) u_hash (
        .bits_i (acc_addr_i[ADDR_W-1:HI_LSB]),
        .hash_o (tag)
    );

    llcprof_stack #(.SETS(MON_SETS), .WAYS(MAX_WAYS), .IDX_W(IDX_W), .POS_W(POS_W)) u_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_en_i      (acc_en),
        .idx_i         (idx),
        .tag_i         (tag),
        .store_i       (acc_store_i),
        .hit_o         (hit),
        .hit_pos_o     (hit_pos),
        .evict_dirty_o (evict_dirty),
        .evict_maxd_o  (evict_maxd)
    );

    llcprof_cnt #(.WAYS(MAX_WAYS), .POS_W(POS_W), .DD_W(DD_W), .CNT_W(CNT_W), .QW_W(QW_W)) u_cnt (
        .clk              (clk),
        .rst_n            (rst_n),
        .clear_i          (clear_i),
        .ev_i             (acc_en),
        .ev_hit_i         (hit),
        .ev_pos_i         (hit_pos),
        .ev_evict_dirty_i (evict_dirty),
        .ev_maxd_i        (evict_maxd),
        .query_i          (query_ways_i),
        .hit_o            (hit_cnt_o),
        .miss_o           (stack_miss_cnt_o),
        .dirty_o          (dirty_cnt_o),
        .est_miss_o       (est_miss_o),
        .est_wb_o         (est_wb_o)
    );

    p_unsampled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !sampled && !clear_i) |=> $stable(stack_miss_cnt_o) && $stable(hit_cnt_o));
endmodule

// File: tb/llcprof_top_tb.sv
`timescale 1ns/1ps
module llcprof_top_tb;
    localparam int MW = 9;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [31:0] acc_addr_i = '0;
    logic        acc_store_i = 1'b0;
    logic [3:0]  query_ways_i = '0;
    logic [MW*32-1:0] hit_cnt_o, dirty_cnt_o;
    logic [31:0] stack_miss_cnt_o, est_miss_o, est_wb_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    llcprof_top u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .acc_valid_i(acc_valid_i),
        .acc_addr_i(acc_addr_i), .acc_store_i(acc_store_i), .query_ways_i(query_ways_i),
        .hit_cnt_o(hit_cnt_o), .stack_miss_cnt_o(stack_miss_cnt_o), .dirty_cnt_o(dirty_cnt_o),
        .est_miss_o(est_miss_o), .est_wb_o(est_wb_o)
    );

    // behavioural reference: per-set list ordered MRU first
    int          m_tag   [NS][MW];
    bit          m_dirty [NS][MW];
    int          m_max   [NS][MW];
    int          m_len   [NS];
    int unsigned r_hit   [MW];
    int unsigned r_dirt  [MW];
    int unsigned r_miss;

    function automatic int fold(input logic [15:0] up);
        int h = 0;
        for (int i = 0; i < 16; i++) if (up[i]) h = h ^ (1 << (i % 11));
        return h;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m_len[s] = 0;
        for (int d = 0; d < MW; d++) begin r_hit[d] = 0; r_dirt[d] = 0; end
        r_miss = 0;
    endtask

    task automatic model_step();
        int s, t, p, tg, mx;
        bit dt;
        if (clear_i) begin
            for (int d = 0; d < MW; d++) begin r_hit[d] = 0; r_dirt[d] = 0; end
            r_miss = 0;
        end
        if (!acc_valid_i || acc_addr_i[10:6] != 5'd0) return;
        s = int'(acc_addr_i[15:11]);
        t = fold(acc_addr_i[31:16]);
        p = -1;
        for (int k = 0; k < m_len[s]; k++) if (p < 0 && m_tag[s][k] == t) p = k;
        if (p >= 0) begin
            r_hit[p]++;
            tg = m_tag[s][p]; dt = m_dirty[s][p]; mx = m_max[s][p];
            if (dt) begin if (p > mx) mx = p; end
            else if (acc_store_i) mx = 0;
            dt = dt | acc_store_i;
            for (int k = p; k > 0; k--) begin
                m_tag[s][k] = m_tag[s][k-1]; m_dirty[s][k] = m_dirty[s][k-1]; m_max[s][k] = m_max[s][k-1];
            end
            m_tag[s][0] = tg; m_dirty[s][0] = dt; m_max[s][0] = mx;
        end else begin
            r_miss++;
            if (m_len[s] == MW) begin
                if (m_dirty[s][MW-1]) r_dirt[m_max[s][MW-1]]++;
            end else m_len[s]++;
            for (int k = m_len[s] - 1; k > 0; k--) begin
                m_tag[s][k] = m_tag[s][k-1]; m_dirty[s][k] = m_dirty[s][k-1]; m_max[s][k] = m_max[s][k-1];
            end
            m_tag[s][0] = t; m_dirty[s][0] = acc_store_i; m_max[s][0] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(input string req, input int unsigned got, input int unsigned exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic compare_all();
        int unsigned em, ew;
        em = r_miss; ew = 0;
        for (int d = 0; d < MW; d++) begin
            chk("R3 hit counter", hit_cnt_o[d*32 +: 32], r_hit[d]);
            chk("R7 dirty counter", dirty_cnt_o[d*32 +: 32], r_dirt[d]);
            if (d >= int'(query_ways_i)) begin em += r_hit[d]; ew += r_dirt[d]; end
        end
        chk("R5 stack miss counter", stack_miss_cnt_o, r_miss);
        chk("R9 miss estimate", est_miss_o, em);
        chk("R10 write-back estimate", est_wb_o, ew);
    endtask

    function automatic logic [31:0] mk(input int up, input int set10);
        return {up[15:0], set10[9:0], 6'd0};
    endfunction

    task automatic acc(input int up, input int set10, input bit st, input bit clr);
        @(negedge clk);
        compare_all();
        acc_valid_i = 1'b1; acc_addr_i = mk(up, set10); acc_store_i = st; clear_i = clr;
    endtask

    task automatic idle();
        @(negedge clk);
        compare_all();
        acc_valid_i = 1'b0; acc_store_i = 1'b0; clear_i = 1'b0;
    endtask

    function automatic int unsigned hitc(input int d); return hit_cnt_o[d*32 +: 32]; endfunction
    function automatic int unsigned dirc(input int d); return dirty_cnt_o[d*32 +: 32]; endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int tot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 miss after reset", stack_miss_cnt_o, 0);
        chk("R11 hit0 after reset", hitc(0), 0);
        chk("R11 est miss after reset", est_miss_o, 0);
        chk("R11 est wb after reset", est_wb_o, 0);

        // R1: unsampled sets, one aliasing shadow index 0 by its upper index bits
        acc(1, 1, 1'b1, 1'b0);
        acc(1, 5, 1'b0, 1'b0);
        acc(2, 17, 1'b1, 1'b0);
        idle();
        chk("R1 unsampled no miss", stack_miss_cnt_o, 0);
        chk("R1 unsampled no dirty", dirc(0), 0);

        // R3/R4/R5: fill shadow set 0 with 9 lines
        for (int u = 1; u <= 9; u++) acc(u, 0, 1'b0, 1'b0);
        acc(1, 0, 1'b0, 1'b0);          // LRU position 8
        acc(9, 0, 1'b0, 1'b0);          // position 1
        idle();
        chk("R5 fill misses (R1 stack untouched)", stack_miss_cnt_o, 9);
        chk("R3 hit at LRU position 8", hitc(8), 1);
        chk("R3 hit at position 1", hitc(1), 1);
        acc(10, 0, 1'b0, 1'b0);         // pushes out line 2
        acc(2, 0, 1'b0, 1'b0);
        idle();
        chk("R4 evicted line misses", stack_miss_cnt_o, 11);

        // R2: 0x0801 folds to the same tag as 0
        acc(0, 32, 1'b0, 1'b0);
        acc(16'h0801, 32, 1'b0, 1'b0);
        idle();
        chk("R2 hash alias hits at MRU", hitc(0), 1);

        // R6/R7: dirty line re-referenced at depth 2, then pushed out
        acc(5, 64, 1'b1, 1'b0);
        acc(6, 64, 1'b0, 1'b0);
        acc(7, 64, 1'b0, 1'b0);
        acc(5, 64, 1'b0, 1'b0);
        for (int u = 20; u <= 28; u++) acc(u, 64, 1'b0, 1'b0);
        idle();
        chk("R6 depth-2 hit recorded", hitc(2), 1);
        chk("R7 dirty bin 2", dirc(2), 1);
        tot = 0;
        for (int d = 0; d < MW; d++) tot += dirc(d);
        chk("R7 clean evictions uncounted", tot, 1);

        // R7: two stores to one line count once
        acc(1, 96, 1'b1, 1'b0);
        acc(1, 96, 1'b1, 1'b0);
        for (int u = 30; u <= 38; u++) acc(u, 96, 1'b0, 1'b0);
        idle();
        chk("R7 single count for repeated stores", dirc(0), 1);
        chk("R5 misses so far", stack_miss_cnt_o, 34);

        // R9/R10: estimates for chosen allocations
        query_ways_i = 4'd0; idle();
        chk("R10 wb estimate W=0", est_wb_o, 2);
        chk("R9 miss estimate W=0", est_miss_o, 39);
        query_ways_i = 4'd1; idle();
        chk("R10 wb estimate W=1", est_wb_o, 1);
        query_ways_i = 4'd3; idle();
        chk("R10 wb estimate W=3", est_wb_o, 0);
        query_ways_i = 4'd9; idle();
        chk("R9 miss estimate W=9", est_miss_o, 34);

        // R8: clear with an access in the same cycle
        acc(99, 0, 1'b0, 1'b1);
        idle();
        chk("R8 same-cycle access counted", stack_miss_cnt_o, 1);
        chk("R8 hits cleared", hitc(0) + hitc(1) + hitc(8), 0);
        chk("R8 dirty cleared", dirc(0) + dirc(2), 0);

        // mixed traffic, model compared every cycle
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            compare_all();
            acc_valid_i  = ($urandom_range(0, 9) < 8);
            acc_store_i  = ($urandom_range(0, 9) < 3);
            clear_i      = ($urandom_range(0, 499) == 0);
            query_ways_i = 4'($urandom_range(0, 9));
            if ($urandom_range(0, 19) == 0)
                acc_addr_i = mk($urandom_range(0, 13), $urandom_range(0, 1023) | 1);
            else if ($urandom_range(0, 29) == 0)
                acc_addr_i = mk(16'h0801, 32 * $urandom_range(0, 3));
            else
                acc_addr_i = mk($urandom_range(0, 13), 32 * $urandom_range(0, 3));
        end
        idle();
        idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule